// File: doc/BRIEF.md
# Interruptible Iterative Integer Divider

This block divides a dividend by a 16-bit divisor one quotient bit per clock and returns a 16-bit quotient with a 16-bit remainder. It handles a double-width (32-bit) or single-width (16-bit) dividend, each signed or unsigned. The double-width dividend arrives as two words, an upper word and a lower word, the way a pair of adjacent registers would supply it. The iteration count depends only on the divisor width, so both dividend widths take the same time. A request takes 19 cycles: one preparation cycle, 16 iteration cycles, one sign-correction cycle and one cycle in which the result is presented.

Requests enter on a valid/ready handshake: `in_ready` is high only while the divider is idle, and a request is taken on a clock edge where `in_valid` and `in_ready` are both high. Results leave on a second valid/ready handshake: `out_valid` stays high and the result stays fixed until `out_ready` is seen high on a clock edge. That back-pressure can last any number of cycles. A plain `hold` input freezes every working register while a division is in progress, so a divide can be paused at any step and resumed without damage. Signed results truncate toward zero. A zero divisor, or a quotient that cannot be held in 16 bits, raises `err` and yields a fixed result.

Top module: `iter_divider`

## Requirements
- R1: `in_ready` is high exactly when the block is idle (neither busy nor presenting a result); a request is taken only on an edge with `in_valid` and `in_ready` both high, and `in_valid` or operand changes at any other time have no effect on the result.
- R2: With `hold` low, `out_valid` rises exactly 18 clock edges after the accepting edge, for both dividend widths; `busy` is high for those 18 cycles.
- R3: Mode `2'b10` (mode[1]=1 double width, mode[0]=0 unsigned) divides {`dividend_hi`,`dividend_lo`} by `divisor` as unsigned numbers; the remainder is less than the divisor.
- R4: Mode `2'b00` divides `dividend_lo` by `divisor` as unsigned numbers, and `dividend_hi` has no effect on the result.
- R5: Modes `2'b11` (double width) and `2'b01` (single width, `dividend_lo` sign-extended) divide as two's complement numbers; the quotient truncates toward zero and a nonzero remainder has the sign of the dividend.
- R6: Each cycle with `hold` high while `busy` is high freezes the division and adds exactly one cycle to the latency; the result is unchanged.
- R7: A zero divisor, an unsigned quotient above 65535, or a signed quotient outside -32768..32767 sets `err`; the quotient is then 16'hFFFF and the remainder 16'h0000.
- R8: While `out_valid` is high and `out_ready` low, `out_valid`, `quotient`, `remainder` and `err` hold their values; after the edge where `out_ready` is high, `out_valid` is low and `in_ready` high.
- R9: After reset `in_ready` is 1 and `busy` and `out_valid` are 0; at most one of `in_ready`, `busy` and `out_valid` is high at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Divider idle and accepting a request |
| dividend_hi | input | 16 | Upper dividend word (used in double-width modes) |
| dividend_lo | input | 16 | Lower dividend word |
| divisor | input | 16 | Divisor |
| mode | input | 2 | Bit 1: double-width dividend; bit 0: signed |
| hold | input | 1 | Freeze the division in progress |
| busy | output | 1 | Division in progress |
| out_valid | output | 1 | Result presented |
| out_ready | input | 1 | Result consumer ready |
| quotient | output | 16 | Quotient |
| remainder | output | 16 | Remainder |
| err | output | 1 | Divide by zero or quotient out of range |

## Verification
On every cycle the assertions check that the three handshake phases exclude each other, that an accepted request turns into `busy`, and that the count of unheld working cycles before `out_valid` is exactly 18. They also check that a held cycle changes no working register, that a result under back-pressure stays fixed, that a zero divisor always reports `err`, and that an unsigned remainder stays below its divisor. The exact quotient and remainder values, truncation toward zero with the sign of the remainder, the range limits that trigger `err`, the ignored upper word in single-width mode and the extra latency from `hold` are shown only by the bench's scenarios against values it computes itself.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_ITER  = 3'd2,
    ST_FIX   = 3'd3,
    ST_OUT   = 3'd4
  } div_state_e;

  // mode field positions
  localparam int MODE_SGN_BIT  = 0;
  localparam int MODE_WIDE_BIT = 1;
endpackage

// File: rtl/div_prep.sv
// Forms the dividend, strips signs and pre-checks unsigned range.
module div_prep #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] hi,
  input  logic [DW-1:0] lo,
  input  logic [DW-1:0] dvs,
  input  logic          wide,
  input  logic          sgn,
  output logic [DW-1:0] mag_hi,
  output logic [DW-1:0] mag_lo,
  output logic [DW-1:0] dmag,
  output logic          q_neg,
  output logic          r_neg,
  output logic          pre_err
);
  localparam int FW = 2 * DW;

  logic [FW-1:0] full;
  logic [FW-1:0] mag;
  logic          dvd_neg;
  logic          dvs_neg;

  always_comb begin
    if (wide)
      full = {hi, lo};
    else if (sgn)
      full = {{DW{lo[DW-1]}}, lo};
    else
      full = {{DW{1'b0}}, lo};
    dvd_neg = sgn & full[FW-1];
    dvs_neg = sgn & dvs[DW-1];
    mag     = dvd_neg ? (~full + 1'b1) : full;
    dmag    = dvs_neg ? (~dvs + 1'b1) : dvs;
    mag_hi  = mag[FW-1:DW];
    mag_lo  = mag[DW-1:0];
    q_neg   = dvd_neg ^ dvs_neg;
    r_neg   = dvd_neg;
    // upper magnitude not below divisor means the quotient needs > DW bits
    pre_err = (dvs == '0) || (mag_hi >= dmag);
  end
endmodule

// File: rtl/div_step.sv
// One restoring step: shift in one dividend bit, trial-subtract.
module div_step #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] rem_in,
  input  logic [DW-1:0] q_in,
  input  logic [DW-1:0] dmag,
  output logic [DW-1:0] rem_out,
  output logic [DW-1:0] q_out
);
  logic [DW:0] shifted;
  logic [DW:0] diff;
  logic        fits;

  always_comb begin
    shifted = {rem_in, q_in[DW-1]};
    diff    = shifted - {1'b0, dmag};
    fits    = shifted >= {1'b0, dmag};
    rem_out = fits ? diff[DW-1:0] : shifted[DW-1:0];
    q_out   = {q_in[DW-2:0], fits};
  end
endmodule

// File: rtl/div_fix.sv
// Restores signs and applies the signed range check.
module div_fix #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] qmag,
  input  logic [DW-1:0] rmag,
  input  logic          q_neg,
  input  logic          r_neg,
  input  logic          sgn,
  input  logic          pre_err,
  output logic [DW-1:0] quo,
  output logic [DW-1:0] rmd,
  output logic          err
);
  localparam logic [DW-1:0] HALF = {1'b1, {(DW-1){1'b0}}};

  logic sgn_ovf;

  always_comb begin
    if (q_neg)
      sgn_ovf = sgn && (qmag > HALF);
    else
      sgn_ovf = sgn && qmag[DW-1];
    err = pre_err | sgn_ovf;
    quo = err ? '1 : (q_neg ? (~qmag + 1'b1) : qmag);
    rmd = err ? '0 : (r_neg ? (~rmag + 1'b1) : rmag);
  end
endmodule

// File: rtl/iter_divider.sv
module iter_divider
  import div_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] dividend_hi,
  input  logic [DW-1:0] dividend_lo,
  input  logic [DW-1:0] divisor,
  input  logic [1:0]    mode,
  input  logic          hold,
  output logic          busy,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] quotient,
  output logic [DW-1:0] remainder,
  output logic          err
);
  localparam int CW   = $clog2(DW);
  localparam int LAT  = DW + 2;
  localparam int LATW = $clog2(LAT + 2);
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  div_state_e    state;
  logic [CW-1:0] cnt;
  logic [DW-1:0] hi_r, lo_r, dvs_r;
  logic          wide_r, sgn_r;
  logic [DW-1:0] rem_r, q_r, dmag_r;
  logic          q_neg_r, r_neg_r, pre_err_r;
  logic [DW-1:0] quo_r, rmd_r;
  logic          err_r;

  logic [DW-1:0] p_hi, p_lo, p_dmag;
  logic          p_qneg, p_rneg, p_err;
  logic [DW-1:0] s_rem, s_q;
  logic [DW-1:0] f_quo, f_rmd;
  logic          f_err;

  assign in_ready  = (state == ST_IDLE);
  assign busy      = (state == ST_SETUP) || (state == ST_ITER) || (state == ST_FIX);
  assign out_valid = (state == ST_OUT);
  assign quotient  = quo_r;
  assign remainder = rmd_r;
  assign err       = err_r;

  div_prep #(.DW(DW)) prep_i (
    .hi(hi_r), .lo(lo_r), .dvs(dvs_r), .wide(wide_r), .sgn(sgn_r),
    .mag_hi(p_hi), .mag_lo(p_lo), .dmag(p_dmag),
    .q_neg(p_qneg), .r_neg(p_rneg), .pre_err(p_err)
  );

  div_step #(.DW(DW)) step_i (
    .rem_in(rem_r), .q_in(q_r), .dmag(dmag_r),
    .rem_out(s_rem), .q_out(s_q)
  );

  div_fix #(.DW(DW)) fix_i (
    .qmag(q_r), .rmag(rem_r), .q_neg(q_neg_r), .r_neg(r_neg_r),
    .sgn(sgn_r), .pre_err(pre_err_r),
    .quo(f_quo), .rmd(f_rmd), .err(f_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      hi_r      <= '0;
      lo_r      <= '0;
      dvs_r     <= '0;
      wide_r    <= 1'b0;
      sgn_r     <= 1'b0;
      rem_r     <= '0;
      q_r       <= '0;
      dmag_r    <= '0;
      q_neg_r   <= 1'b0;
      r_neg_r   <= 1'b0;
      pre_err_r <= 1'b0;
      quo_r     <= '0;
      rmd_r     <= '0;
      err_r     <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (in_valid) begin
            hi_r   <= dividend_hi;
            lo_r   <= dividend_lo;
            dvs_r  <= divisor;
            wide_r <= mode[MODE_WIDE_BIT];
            sgn_r  <= mode[MODE_SGN_BIT];
            state  <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          if (!hold) begin
            rem_r     <= p_hi;
            q_r       <= p_lo;
            dmag_r    <= p_dmag;
            q_neg_r   <= p_qneg;
            r_neg_r   <= p_rneg;
            pre_err_r <= p_err;
            cnt       <= '0;
            state     <= ST_ITER;
          end
        end
        ST_ITER: begin
          if (!hold) begin
            rem_r <= s_rem;
            q_r   <= s_q;
            cnt   <= cnt + 1'b1;
            if (cnt == LAST) state <= ST_FIX;
          end
        end
        ST_FIX: begin
          if (!hold) begin
            quo_r <= f_quo;
            rmd_r <= f_rmd;
            err_r <= f_err;
            state <= ST_OUT;
          end
        end
        ST_OUT: begin
          if (out_ready) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // ---------------- assertions ----------------
  // checker counter: unheld working cycles since the accepting edge
  logic [LATW-1:0] lat_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      lat_cnt <= '0;
    else if (in_valid && in_ready)
      lat_cnt <= '0;
    else if (busy && !hold)
      lat_cnt <= lat_cnt + 1'b1;
  end

  assert_accept_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> busy && !in_ready);

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> lat_cnt == LATW'(LAT));

  assert_rem_below_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !err && !sgn_r |-> remainder < dvs_r);

  assert_hold_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy && hold |=> state == $past(state) && $stable(q_r) && $stable(rem_r) && $stable(cnt));

  assert_div0_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && dvs_r == '0 |-> err);

  assert_backpressure_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(quotient) && $stable(remainder) && $stable(err));

  assert_phase_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({in_ready, busy, out_valid}));
endmodule

// File: tb/iter_divider_tb_top.sv
module iter_divider_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] dividend_hi = '0;
  logic [15:0] dividend_lo = '0;
  logic [15:0] divisor = '0;
  logic [1:0]  mode = '0;
  logic        hold = 1'b0;
  logic        busy;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [15:0] quotient;
  logic [15:0] remainder;
  logic        err;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  iter_divider dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .dividend_hi(dividend_hi), .dividend_lo(dividend_lo), .divisor(divisor),
    .mode(mode), .hold(hold), .busy(busy), .out_valid(out_valid),
    .out_ready(out_ready), .quotient(quotient), .remainder(remainder), .err(err)
  );

  task automatic chk(input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // expected result computed from the requirements
  task automatic model(input logic [15:0] hi, input logic [15:0] lo,
                       input logic [15:0] d, input logic [1:0] m,
                       output logic [15:0] eq, output logic [15:0] er,
                       output logic ee);
    longint dvd, dv, q, r;
    if (m[0]) begin
      dvd = m[1] ? longint'($signed({hi, lo})) : longint'($signed(lo));
      dv  = longint'($signed(d));
    end else begin
      dvd = m[1] ? longint'({hi, lo}) : longint'(lo);
      dv  = longint'(d);
    end
    ee = 1'b0;
    q = 0;
    r = 0;
    if (dv == 0) ee = 1'b1;
    else begin
      q = dvd / dv;
      r = dvd % dv;
      if (m[0]) ee = (q > 32767) || (q < -32768);
      else      ee = (q > 65535);
    end
    eq = ee ? 16'hFFFF : q[15:0];
    er = ee ? 16'h0000 : r[15:0];
  endtask

  // one division; hs/hl: hold start and length, bp: back-pressure cycles,
  // stray: offer another request while busy
  task automatic run(input string req, input logic [15:0] hi,
                     input logic [15:0] lo, input logic [15:0] d,
                     input logic [1:0] m, input int hs, input int hl,
                     input int bp, input bit stray);
    logic [15:0] eq, er;
    logic ee;
    int n;
    model(hi, lo, d, m, eq, er, ee);
    @(negedge clk);
    chk("R1", "in_ready idle", in_ready, 1);
    dividend_hi = hi; dividend_lo = lo; divisor = d; mode = m;
    in_valid = 1'b1;
    out_ready = 1'b0;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    n = 0;
    while (!out_valid && n < 100) begin
      hold = (n >= hs) && (n < hs + hl);
      if (stray && n == 3) begin
        in_valid = 1'b1;
        dividend_hi = ~hi; dividend_lo = ~lo; divisor = d + 16'd3; mode = ~m;
        chk("R1", "in_ready while busy", in_ready, 0);
      end
      @(posedge clk);
      n++;
      @(negedge clk);
      in_valid = 1'b0;
      if (n == 2) chk("R2", "busy during divide", busy, 1);
    end
    hold = 1'b0;
    chk(hl > 0 ? "R6" : "R2", "latency", n, 18 + hl);
    chk(req, "quotient", quotient, eq);
    chk(req, "remainder", remainder, er);
    chk(req, "err", err, ee);
    for (int i = 0; i < bp; i++) begin
      @(posedge clk);
      @(negedge clk);
      chk("R8", "held valid", out_valid, 1);
      chk("R8", "held quotient", quotient, eq);
    end
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    out_ready = 1'b0;
    chk("R8", "valid drops", out_valid, 0);
    chk("R8", "ready returns", in_ready, 1);
  endtask

  task automatic t_reset();
    chk("R9", "in_ready", in_ready, 1);
    chk("R9", "busy", busy, 0);
    chk("R9", "out_valid", out_valid, 0);
  endtask

  task automatic t_unsigned32();
    run("R3", 16'h0012, 16'h3456, 16'h1234, 2'b10, 0, 0, 0, 0);
    run("R3", 16'hFFFE, 16'hFFFF, 16'hFFFF, 2'b10, 0, 0, 0, 0);
    run("R3", 16'h0000, 16'h0005, 16'h0009, 2'b10, 0, 0, 0, 0);
  endtask

  task automatic t_unsigned16();
    run("R4", 16'h0000, 16'd50000, 16'd7, 2'b00, 0, 0, 0, 0);
    run("R4", 16'hDEAD, 16'd50000, 16'd7, 2'b00, 0, 0, 0, 0);
    run("R4", 16'hFFFF, 16'hFFFF, 16'h0001, 2'b00, 0, 0, 0, 0);
  endtask

  task automatic t_signed();
    logic [31:0] v;
    v = -32'sd100000;
    run("R5", v[31:16], v[15:0], 16'd7, 2'b11, 0, 0, 0, 0);
    v = 32'sd100000;
    run("R5", v[31:16], v[15:0], -16'sd7, 2'b11, 0, 0, 0, 0);
    run("R5", 16'h0000, -16'sd7, 16'd2, 2'b01, 0, 0, 0, 0);
    run("R5", 16'h1234, 16'h8000, 16'h0001, 2'b01, 0, 0, 0, 0);
    run("R5", 16'h0000, -16'sd9, -16'sd4, 2'b01, 0, 0, 0, 0);
  endtask

  task automatic t_hold();
    run("R6", 16'h0003, 16'h0C00, 16'h00F1, 2'b10, 0, 2, 0, 0);
    run("R6", 16'h0003, 16'h0C00, 16'h00F1, 2'b10, 8, 5, 0, 0);
    run("R6", 16'h0000, -16'sd300, 16'd11, 2'b01, 16, 1, 0, 0);
  endtask

  task automatic t_error();
    run("R7", 16'h0001, 16'h0000, 16'h0000, 2'b10, 0, 0, 0, 0);
    run("R7", 16'h0001, 16'h0000, 16'h0001, 2'b10, 0, 0, 0, 0);
    run("R7", 16'h0000, 16'h8000, 16'hFFFF, 2'b01, 0, 0, 0, 0);
    run("R7", 16'h0000, 16'h8000, 16'h0001, 2'b11, 0, 0, 0, 0);
    run("R7", 16'hFFFF, 16'h8000, 16'h0001, 2'b11, 0, 0, 0, 0);
  endtask

  task automatic t_backpressure();
    run("R8", 16'h0007, 16'hA120, 16'h0100, 2'b10, 0, 0, 4, 0);
  endtask

  task automatic t_stray();
    run("R1", 16'h0002, 16'h0000, 16'h0300, 2'b10, 0, 0, 0, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_unsigned32();
    t_unsigned16();
    t_signed();
    t_hold();
    t_error();
    t_backpressure();
    t_stray();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule